// File: doc/BRIEF.md
# Prescaled Auto-Reload Bit-Rate Tick Generator

This block turns the system clock into the timing tick that paces a UART's bit shifters. A small prescaler divides the clock by one of four fixed ratios, and each prescaled strobe advances a 16-bit up-counter. When the counter passes its maximum value it reloads a software-programmed start value and emits a one-cycle tick. The tick period is therefore `(65536 - reload) * divide` clock cycles.

Software programs the reload value one byte at a time through a simple write port. A select bit picks the low or the high byte. A new reload value does not disturb the count in progress. The counter picks it up the next time it wraps. A single enable input starts the generator and stops it. While stopped, the prescaler sits at zero and the counter holds the reload value, so enabling it always begins a full, clean period.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is low and both reload bytes are zero.
- R2: The prescale code sets the strobe divide: code 2'b00 divides by 1, 2'b01 by 4, 2'b10 by 12 and 2'b11 by 48.
- R3: While enabled, the counter steps up by one on each prescaler strobe. The strobe that finds it at 16'hFFFF reloads it, so ticks are spaced `(65536 - reload) * divide` clock cycles apart.
- R4: `tick` is high for exactly one clock cycle per overflow. This holds whenever the period is two cycles or more.
- R5: A write with `wr_en` high and `wr_hi` low stores `wr_data` into reload bits [7:0]. A write with `wr_hi` high stores it into bits [15:8]. Each write leaves the other byte unchanged.
- R6: A reload value written while the generator runs does not change the period in progress. It sets the length of every period after the next overflow.
- R7: While `enable` is low, no tick is produced. The prescaler is held at zero and the counter is held at the reload value.
- R8: Counting the first clock edge with `enable` high as edge 1, the first tick after enabling follows edge `(65536 - reload) * divide`. This also applies when the generator is re-enabled after being stopped partway through a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run (1) or hold (0) the generator |
| prescale | input | 2 | Prescaler divide code |
| wr_en | input | 1 | Reload byte write strobe |
| wr_hi | input | 1 | Byte select for the write: 0 low byte, 1 high byte |
| wr_data | input | 8 | Reload byte to store |
| tick | output | 1 | One-cycle overflow pulse |

## Verification
The hardest case to reach is a reload value that changes while the counter is mid-period. The old value must still govern the period in progress, and the new value must take over only at the wrap. To reach it, the bench starts the generator with a long period and then rewrites both reload bytes early in that first period. Its scoreboard queue holds one old-length interval followed by new-length intervals. A second hard case is stopping partway through a period and then restarting. The bench disables the generator well before the first overflow and then expects one full period after re-enabling, so any leftover prescaler or counter state would show up as a short interval.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'b00,
        PS_DIV4  = 2'b01,
        PS_DIV12 = 2'b10,
        PS_DIV48 = 2'b11
    } presc_sel_e;

    localparam int PS_CNT_W = 6;

    // Terminal count of the prescaler (divide ratio minus one)
    function automatic logic [PS_CNT_W-1:0] presc_limit(input presc_sel_e sel);
        case (sel)
            PS_DIV1:  return PS_CNT_W'(0);
            PS_DIV4:  return PS_CNT_W'(3);
            PS_DIV12: return PS_CNT_W'(11);
            default:  return PS_CNT_W'(47);
        endcase
    endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] sel_i,
    output logic       stb_o
);

    typedef struct packed {
        logic [PS_CNT_W-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [PS_CNT_W-1:0] limit;

    always_comb begin
        limit = presc_limit(presc_sel_e'(sel_i));
        stb_o = en_i && (st_q.cnt >= limit);
        st_d  = st_q;
        if (!en_i || stb_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a stopped generator leaves the prescaler at zero
    p_presc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cnt == '0));

    // R2: with a steady code, strobes are never closer than the divide ratio
    p_presc_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && sel_i != 2'b00) |=> !stb_o);

endmodule

// File: rtl/baud_reload_regs.sv
module baud_reload_regs #(
    parameter int BYTE_W = 8,
    localparam int RELOAD_W = 2 * BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic                wr_hi_i,
    input  logic [BYTE_W-1:0]   wr_data_i,
    output logic [RELOAD_W-1:0] reload_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } rl_state_t;

    rl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_hi_i) st_d.hi = wr_data_i;
            else         st_d.lo = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = {st_q.hi, st_q.lo};

    // R5: a low-byte write lands in the low byte and spares the high byte
    p_low_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_hi_i) |=>
            (reload_o[BYTE_W-1:0] == $past(wr_data_i)) &&
            (reload_o[RELOAD_W-1:BYTE_W] == $past(reload_o[RELOAD_W-1:BYTE_W])));

    // R5: a high-byte write lands in the high byte and spares the low byte
    p_high_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_hi_i) |=>
            (reload_o[RELOAD_W-1:BYTE_W] == $past(wr_data_i)) &&
            (reload_o[BYTE_W-1:0] == $past(reload_o[BYTE_W-1:0])));

endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               stb_i,
    input  logic [TIMER_W-1:0] reload_i,
    output logic               tick_o
);

    localparam logic [TIMER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [TIMER_W-1:0] cnt;
        logic               tick;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!en_i) begin
            st_d.cnt = reload_i;
        end else if (stb_i) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.cnt  = reload_i;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R7: no tick follows a cycle spent disabled
    p_no_tick_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick_o);

    // R3: a tick always comes with the counter freshly reloaded
    p_reload_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (st_q.cnt == $past(reload_i)));

    // R3: without a strobe the running counter does not move
    p_hold_no_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !stb_i) |=> $stable(st_q.cnt));

    // R6: the counter takes the reload value only on a wrap or while stopped
    p_no_midcount_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stb_i && st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int TIMER_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        prescale,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick
);

    logic               presc_stb;
    logic [TIMER_W-1:0] reload_val;

    baud_reload_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_hi_i   (wr_hi),
        .wr_data_i (wr_data),
        .reload_o  (reload_val)
    );

    baud_prescaler u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (enable),
        .sel_i (prescale),
        .stb_o (presc_stb)
    );

    baud_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (enable),
        .stb_i    (presc_stb),
        .reload_i (reload_val),
        .tick_o   (tick)
    );

    // R1: the output is quiet in the first cycle out of reset
    p_tick_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !tick);

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] prescale = 2'b00;
    logic       wr_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    string req_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
        .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data), .tick(tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] sel);
        case (sel)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 12;
            default: return 48;
        endcase
    endfunction

    function automatic int period(input logic [1:0] sel, input int r);
        return (65536 - r) * div_of(sel);
    endfunction

    // Monitor: counts enabled edges and scores each tick against the queue
    initial begin
        int cnt = 0;
        bit prev = 1'b0;
        forever begin
            @(posedge clk);
            if (enable) cnt++;
            else cnt = 0;
            @(negedge clk);
            if (prev) check(tick == 1'b0, "R4", "tick wider than one cycle", tick, 0);
            if (tick) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected tick", cnt, -1);
                end else begin
                    int e;
                    string rq;
                    e  = exp_q.pop_front();
                    rq = req_q.pop_front();
                    check(cnt == e, rq, "tick interval", cnt, e);
                end
                cnt = 0;
            end
            prev = tick;
        end
    end

    task automatic wr(input bit hi, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_reload(input int r);
        wr(1'b0, r[7:0]);
        wr(1'b1, r[15:8]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(posedge clk);
        #1;
        enable = 1'b0;
        idle(3);
    endtask

    task automatic run_case(input logic [1:0] sel, input int r, input int n, input string rq);
        enable = 1'b0;
        prescale = sel;
        set_reload(r);
        idle(2);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(period(sel, r));
            req_q.push_back(rq);
        end
        @(posedge clk); #1;
        enable = 1'b1;
        wait_drain();
    endtask

    initial begin
        idle(3);
        #1;
        @(negedge clk);
        check(tick == 1'b0, "R1", "tick in reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick == 1'b0, "R1", "tick after reset", tick, 0);

        // R1: reload bytes reset to zero -> divide-by-1 period would be 65536;
        // observe via high byte write only: low byte must still be zero
        enable = 1'b0; prescale = 2'b00;
        wr(1'b1, 8'hFF);
        idle(2);
        exp_q.push_back(256); req_q.push_back("R1");
        @(posedge clk); #1; enable = 1'b1;
        wait_drain();

        // R2/R3/R8: each prescale code
        run_case(2'b00, 16'hFFF0, 3, "R3");
        run_case(2'b01, 16'hFFF6, 3, "R2");
        run_case(2'b10, 16'hFFFB, 2, "R2");
        run_case(2'b11, 16'hFFFD, 2, "R2");
        run_case(2'b11, 16'hFFFF, 2, "R8");
        run_case(2'b00, 16'hFFFE, 3, "R4");

        // R5: low-byte write alone keeps high byte (FF)
        enable = 1'b0; prescale = 2'b00;
        set_reload(16'h1200);
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'hE4);
        idle(2);
        exp_q.push_back(period(2'b00, 16'hFFE4)); req_q.push_back("R5");
        @(posedge clk); #1; enable = 1'b1;
        wait_drain();

        // R6: rewrite reload early in a running period
        enable = 1'b0; prescale = 2'b01;
        set_reload(16'hFFE0);
        idle(2);
        exp_q.push_back(period(2'b01, 16'hFFE0)); req_q.push_back("R6");
        exp_q.push_back(period(2'b01, 16'hFFF8)); req_q.push_back("R6");
        exp_q.push_back(period(2'b01, 16'hFFF8)); req_q.push_back("R6");
        @(posedge clk); #1; enable = 1'b1;
        set_reload(16'hFFF8);
        wait_drain();

        // R7/R8: stop partway through, stay quiet, restart with a full period
        enable = 1'b0; prescale = 2'b10;
        set_reload(16'hFFE0);
        idle(2);
        @(posedge clk); #1; enable = 1'b1;
        idle(200);
        #1; enable = 1'b0;
        idle(50);
        @(negedge clk);
        check(tick == 1'b0, "R7", "tick while disabled", tick, 0);
        exp_q.push_back(period(2'b10, 16'hFFE0)); req_q.push_back("R8");
        @(posedge clk); #1; enable = 1'b1;
        wait_drain();
        @(negedge clk);
        check(exp_q.size() == 0, "R7", "pending expectations", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) check(1'b0, "WDOG", "watchdog expired", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule